// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Address Walker

The walker turns a 32-bit linear address into a physical address of up to 40 bits. It reads 32-bit entries from a directory and from a page table through a single memory read port. A requester presents the linear address and the directory base, together with the paging, protection and large-page enables. The walker then fetches one entry at a time. It returns either a physical address or a not-present fault as a one-cycle response.

When large pages are enabled and a directory entry has its page-size bit set, the walk stops at the directory. In that case the entry supplies physical bits [39:22], and eight of those bits come from the middle of the entry. Without a large page, the walk reads a page-table entry and returns a 4 KiB frame below the 4 GiB line. When paging or protection is off, the linear address passes straight through.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1, and `mem_req_o` and `rsp_valid_o` are 0.
- R2: Unless both `pg_en_i` and `pe_en_i` are 1 at acceptance, the walker makes no memory read. It raises `rsp_valid_o` in the cycle after acceptance with `rsp_fault_o`=0 and `rsp_pa_o` = zero-extended linear address.
- R3: The first read goes to address {8'h00, base[31:12], la[31:22], 2'b00}.
- R4: Bit 0 of every fetched entry is the present bit. If it is clear, the walk ends with `rsp_fault_o`=1 and `rsp_pa_o`=0, and no further read is made.
- R5: When large pages are enabled and directory entry bit 7 is 1, no second read is made. The result is {pde[20:13], pde[31:22], la[21:0]}.
- R6: The second read goes to address {8'h00, pde[31:12], la[21:12], 2'b00}.
- R7: A present table entry gives {8'h00, pte[31:12], la[11:0]}.
- R8: With large pages disabled, directory entry bit 7 is ignored and the two-level walk is always made.
- R9: Only one read is outstanding at a time. `mem_req_o` stays high until `mem_valid_i` arrives, and `mem_valid_i` outside a fetch has no effect.
- R10: `rsp_valid_o` is a single-cycle pulse. `req_ready_o` is high only while idle, never together with `mem_req_o` or `rsp_valid_o`.
- R11: The linear address, base and all enables are sampled at acceptance. Changing them mid-walk does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_la_i | input | 32 | Linear address |
| req_base_i | input | 32 | Directory base (bits [31:12] used) |
| pg_en_i | input | 1 | Paging enable |
| pe_en_i | input | 1 | Protection enable |
| lp_en_i | input | 1 | Large-page enable |
| mem_req_o | output | 1 | Entry read request, held until data |
| mem_addr_o | output | 40 | Entry address |
| mem_valid_i | input | 1 | Entry data valid |
| mem_data_i | input | 32 | Entry data |
| rsp_valid_o | output | 1 | Result pulse |
| rsp_pa_o | output | 40 | Physical address |
| rsp_fault_o | output | 1 | Not-present fault |

## Verification
The bench sweeps linear addresses, read latencies, entry kinds and the large-page enable. It goes after the cases that separate the modes.

- A directory entry with bit 7 set while large pages are disabled must still trigger a table read. A walker that honoured the bit would return a 40-bit address and skip the read.
- A clear present bit at either level must give a zero address and a fault. A walker that leaked the frame or kept fetching would show the wrong read count.
- Dropping the enables or changing the address just after acceptance exposes a walker that reads its ports live rather than latched values.
- A stray data strobe while idle exposes a walker that reacts to it.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_DIR  = 2'd1,
    WS_TBL  = 2'd2,
    WS_DONE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr #(
  parameter int LA_W      = 32,
  parameter int PA_W      = 40,
  parameter int ENT_W     = 32,
  parameter int OFF_W     = 12,
  parameter int IDX_W     = 10,
  parameter int LP_HI_LSB = 13
) (
  input  logic [LA_W-1:0]  la_i,
  input  logic [ENT_W-1:0] base_i,
  input  logic [ENT_W-1:0] pde_live_i,
  input  logic [ENT_W-1:0] pde_q_i,
  input  logic [ENT_W-1:0] pte_i,
  output logic [PA_W-1:0]  dir_addr_o,
  output logic [PA_W-1:0]  tbl_addr_o,
  output logic [PA_W-1:0]  big_pa_o,
  output logic [PA_W-1:0]  small_pa_o
);
  localparam int HI_W  = PA_W - LA_W;
  localparam int FRM_W = ENT_W - OFF_W;
  localparam int BIG_W = OFF_W + IDX_W;
  localparam int ES_W  = OFF_W - IDX_W;

  always_comb begin
    dir_addr_o = {{HI_W{1'b0}}, base_i[ENT_W-1:OFF_W], la_i[LA_W-1:BIG_W], {ES_W{1'b0}}};
    tbl_addr_o = {{HI_W{1'b0}}, pde_q_i[ENT_W-1:OFF_W], la_i[BIG_W-1:OFF_W], {ES_W{1'b0}}};
    big_pa_o   = {pde_live_i[LP_HI_LSB+HI_W-1:LP_HI_LSB], pde_live_i[ENT_W-1:BIG_W],
                  la_i[BIG_W-1:0]};
    small_pa_o = {{HI_W{1'b0}}, pte_i[ENT_W-1:OFF_W], la_i[OFF_W-1:0]};
  end

  logic unused_ok;
  assign unused_ok = ^{base_i[OFF_W-1:0], pde_q_i[OFF_W-1:0], pte_i[OFF_W-1:0],
                       pde_live_i[BIG_W-1:LP_HI_LSB+HI_W], pde_live_i[LP_HI_LSB-1:0]};
  if (FRM_W <= 0) begin : g_bad_width
    initial $display("pt_walker_addr: entry narrower than page offset");
  end
endmodule

// File: rtl/pt_walker_fsm.sv
module pt_walker_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        xlate_i,
  input  logic        lp_q_i,
  input  logic        mem_valid_i,
  input  logic        present_i,
  input  logic        ps_i,
  output walk_state_e state_o
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE: if (req_valid_i) state_d = xlate_i ? WS_DIR : WS_DONE;
      WS_DIR:  if (mem_valid_i) state_d = (!present_i || (lp_q_i && ps_i)) ? WS_DONE : WS_TBL;
      WS_TBL:  if (mem_valid_i) state_d = WS_DONE;
      WS_DONE: state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WS_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_fetch_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == WS_DIR || state_q == WS_TBL) && !mem_valid_i) |=> $stable(state_q));
  assert_done_leaves_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WS_DONE) |=> (state_q == WS_IDLE));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int LA_W      = 32,
  parameter int PA_W      = 40,
  parameter int ENT_W     = 32,
  parameter int PS_BIT    = 7,
  parameter int P_BIT     = 0,
  parameter int LP_HI_LSB = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [LA_W-1:0]  req_la_i,
  input  logic [ENT_W-1:0] req_base_i,
  input  logic             pg_en_i,
  input  logic             pe_en_i,
  input  logic             lp_en_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [ENT_W-1:0] mem_data_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic             rsp_fault_o
);
  localparam int HI_W = PA_W - LA_W;

  walk_state_e       state;
  logic [LA_W-1:0]   la_q;
  logic [ENT_W-1:0]  base_q, pde_q;
  logic              lp_q;
  logic [PA_W-1:0]   pa_q;
  logic              fault_q;
  logic [PA_W-1:0]   dir_addr, tbl_addr, big_pa, small_pa;
  logic              xlate, accept, dir_hit, tbl_hit, present, ps;

  assign xlate   = pg_en_i & pe_en_i;
  assign accept  = (state == WS_IDLE) & req_valid_i;
  assign dir_hit = (state == WS_DIR) & mem_valid_i;
  assign tbl_hit = (state == WS_TBL) & mem_valid_i;
  assign present = mem_data_i[P_BIT];
  assign ps      = mem_data_i[PS_BIT];

  pt_walker_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .xlate_i     (xlate),
    .lp_q_i      (lp_q),
    .mem_valid_i (mem_valid_i),
    .present_i   (present),
    .ps_i        (ps),
    .state_o     (state)
  );

  pt_walker_addr #(
    .LA_W(LA_W), .PA_W(PA_W), .ENT_W(ENT_W), .LP_HI_LSB(LP_HI_LSB)
  ) u_addr (
    .la_i       (la_q),
    .base_i     (base_q),
    .pde_live_i (mem_data_i),
    .pde_q_i    (pde_q),
    .pte_i      (mem_data_i),
    .dir_addr_o (dir_addr),
    .tbl_addr_o (tbl_addr),
    .big_pa_o   (big_pa),
    .small_pa_o (small_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      la_q    <= '0;
      base_q  <= '0;
      pde_q   <= '0;
      lp_q    <= 1'b0;
      pa_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      if (accept) begin
        la_q    <= req_la_i;
        base_q  <= req_base_i;
        lp_q    <= lp_en_i;
        pa_q    <= {{HI_W{1'b0}}, req_la_i};
        fault_q <= 1'b0;
      end
      if (dir_hit) begin
        pde_q <= mem_data_i;
        if (!present) begin
          pa_q    <= '0;
          fault_q <= 1'b1;
        end else if (lp_q && ps) begin
          pa_q <= big_pa;
        end
      end
      if (tbl_hit) begin
        pa_q    <= present ? small_pa : '0;
        fault_q <= !present;
      end
    end
  end

  always_comb begin
    mem_addr_o = '0;
    if (state == WS_DIR)      mem_addr_o = dir_addr;
    else if (state == WS_TBL) mem_addr_o = tbl_addr;
  end

  assign req_ready_o = (state == WS_IDLE);
  assign mem_req_o   = (state == WS_DIR) || (state == WS_TBL);
  assign rsp_valid_o = (state == WS_DONE);
  assign rsp_pa_o    = pa_q;
  assign rsp_fault_o = fault_q;

  assert_req_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> mem_req_o);
  assert_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_ready_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && (mem_req_o || rsp_valid_o)));
  assert_fault_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0));
  assert_np_fault_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i && !mem_data_i[P_BIT]) |=> (rsp_valid_o && rsp_fault_o));
  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !(pg_en_i && pe_en_i)) |=>
      (rsp_valid_o && !rsp_fault_o && rsp_pa_o == {{HI_W{1'b0}}, $past(req_la_i)}));
endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_la = '0, req_base = '0;
  logic        pg = 1'b0, pe = 1'b0, lp = 1'b0;
  logic        mem_req;
  logic [39:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_data;
  logic        rsp_valid;
  logic [39:0] rsp_pa;
  logic        rsp_fault;

  int total = 0, bad = 0;
  logic [31:0] pde_v, pte_v;
  int lat = 1, rd_cnt = 0, cnt = 0;
  logic [39:0] rd_a0, rd_a1;
  bit inject = 1'b0;

  always #10 clk = ~clk;

  pt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_la_i(req_la), .req_base_i(req_base), .pg_en_i(pg), .pe_en_i(pe), .lp_en_i(lp),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid),
    .mem_data_i(mem_data), .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa),
    .rsp_fault_o(rsp_fault)
  );

  task automatic chk(input bit ok, input string rq, input logic [39:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // memory model: one response per held request after lat cycles
  initial begin
    mem_valid = 1'b0;
    mem_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_valid) begin
        mem_valid = 1'b0;
        mem_data  = '0;
      end else if (inject) begin
        mem_valid = 1'b1;
        mem_data  = 32'hFFFF_FFFF;
        inject    = 1'b0;
      end else if (mem_req) begin
        cnt++;
        if (cnt >= lat) begin
          cnt       = 0;
          mem_valid = 1'b1;
          mem_data  = (rd_cnt == 0) ? pde_v : pte_v;
          if (rd_cnt == 0) rd_a0 = mem_addr;
          else             rd_a1 = mem_addr;
          rd_cnt++;
        end
      end
    end
  end

  function automatic logic [31:0] mix(input int k);
    return (32'(k) + 32'd1) * 32'h9E37_79B1 ^ (32'(k) << 13);
  endfunction

  task automatic walk(input logic [31:0] la, base, input bit g, e, l,
                      input logic [31:0] pde, pte, input int lt, input bit flip);
    logic [39:0] exp_pa, a0, a1;
    bit exp_f;
    int exp_rd, n;
    bit xl;
    xl = g && e;
    a0 = {8'h00, base[31:12], la[31:22], 2'b00};
    a1 = {8'h00, pde[31:12], la[21:12], 2'b00};
    exp_f = 1'b0;
    if (!xl) begin
      exp_pa = {8'h00, la}; exp_rd = 0;
    end else if (!pde[0]) begin
      exp_pa = '0; exp_f = 1'b1; exp_rd = 1;
    end else if (l && pde[7]) begin
      exp_pa = {pde[20:13], pde[31:22], la[21:0]}; exp_rd = 1;
    end else if (!pte[0]) begin
      exp_pa = '0; exp_f = 1'b1; exp_rd = 2;
    end else begin
      exp_pa = {8'h00, pte[31:12], la[11:0]}; exp_rd = 2;
    end
    @(negedge clk);
    pde_v = pde; pte_v = pte; lat = lt; rd_cnt = 0; cnt = 0;
    req_la = la; req_base = base; pg = g; pe = e; lp = l; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R10 ready in idle", {39'b0, req_ready}, 40'h1);
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) begin  // R11: disturb inputs after acceptance
      lp = ~l; pg = 1'b0; pe = 1'b0; req_la = ~la; req_base = ~base;
    end
    n = 1;
    while (!rsp_valid && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, "R10 response seen", {39'b0, rsp_valid}, 40'h1);
    chk(rsp_pa == exp_pa, exp_f ? "R4 fault address" :
        (!xl ? "R2 bypass address" : ((l && pde[7]) ? "R5 large page" : "R7 small page")),
        rsp_pa, exp_pa);
    chk(rsp_fault == exp_f, "R4 fault flag", {39'b0, rsp_fault}, {39'b0, exp_f});
    chk(rd_cnt == exp_rd, (!l && pde[7]) ? "R8 read count" : "R4 R5 read count",
        40'(rd_cnt), 40'(exp_rd));
    if (exp_rd >= 1) chk(rd_a0 == a0, "R3 directory address", rd_a0, a0);
    if (exp_rd == 2) chk(rd_a1 == a1, "R6 table address", rd_a1, a1);
    if (!xl) chk(n == 1, "R2 bypass latency", 40'(n), 40'h1);
    chk(!mem_req, "R9 no request at response", {39'b0, mem_req}, 40'h0);
    @(negedge clk);
    chk(!rsp_valid, "R10 single pulse", {39'b0, rsp_valid}, 40'h0);
    lp = l; pg = g; pe = e;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", {39'b0, req_ready}, 40'h1);
    chk(!mem_req && !rsp_valid, "R1 idle outputs", {38'b0, mem_req, rsp_valid}, 40'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req && !rsp_valid, "R1 after reset",
        {37'b0, req_ready, mem_req, rsp_valid}, 40'h4);

    // R2: each non-translating enable combination
    walk(32'hDEAD_BEEF, 32'h1234_5000, 1'b0, 1'b0, 1'b1, 32'h1, 32'h1, 1, 1'b0);
    walk(32'h8000_0FFF, 32'h1234_5000, 1'b1, 1'b0, 1'b0, 32'h1, 32'h1, 1, 1'b0);
    walk(32'h0040_1234, 32'h1234_5000, 1'b0, 1'b1, 1'b0, 32'h1, 32'h1, 2, 1'b0);

    // R9: stray data strobe while idle
    @(negedge clk);
    inject = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "R9 stray strobe ignored",
          {37'b0, req_ready, rsp_valid, mem_req}, 40'h4);
    end

    // sweep: latency x address x entry kind x large-page enable x table present
    for (int lt = 1; lt <= 3; lt++)
      for (int p = 0; p < 8; p++)
        for (int kind = 0; kind < 3; kind++)
          for (int l = 0; l < 2; l++)
            for (int tp = 0; tp < 2; tp++) begin
              logic [31:0] la, base, pde, pte;
              la   = mix(p * 7 + lt);
              base = mix(p + 100);
              pde  = (mix(p + 200) & ~32'h81) | ((kind != 0) ? 32'h1 : 32'h0)
                     | ((kind == 2) ? 32'h80 : 32'h0);
              pte  = (mix(p + 300) & ~32'h1) | 32'(tp);
              walk(la, base, 1'b1, 1'b1, l[0], pde, pte, lt, 1'b0);
            end

    // R11: inputs disturbed after acceptance
    walk(32'hFFC0_3ABC, 32'hABCD_E000, 1'b1, 1'b1, 1'b1, 32'hA5F3_E081, 32'h0, 2, 1'b1);
    walk(32'h1357_9BDF, 32'h0F0F_0000, 1'b1, 1'b1, 1'b0, 32'hCAFE_B0FF, 32'h7654_3001, 3, 1'b1);
    walk(32'h2468_ACE0, 32'h0000_1000, 1'b0, 1'b1, 1'b1, 32'h1, 32'h1, 1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule